// File: doc/BRIEF.md
# Low-Power Mode Controller

This block picks the power mode of a processor core and drives the enables that go with it. Software asks for a mode through a request handshake. The controller then gates the CPU clock, turns off the two PLLs, or drops the low-voltage and high-voltage supply enables, one further step for each deeper mode. It decides which event ends the current mode. In the two idle modes that is an interrupt or an enabled wake event. In the three deeper modes only an enabled wake event can end the mode.

Leaving standby keeps the state of the core, so execution simply continues. Leaving sleep or deep sleep goes back to normal mode and raises a one-cycle warm-reset request, so the core reboots from address 0x0. A request that is not allowed is ignored and sets a sticky error flag. Two cases count as not allowed: deep idle while the core clock is not on the 13 MHz source, and an undefined mode code.

The wake inputs are asynchronous. They pass through a two-flop synchroniser and a rising-edge detector, and are then masked by their per-bit enables.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset the controller is in normal mode (mode_code 0). In that state cpu_clk_en, both pll_en bits, lv_supply_en and hv_supply_en are 1, while warm_rst_req and req_err are 0.
- R2: The mode codes are 0 normal, 1 idle, 2 deep idle, 3 standby, 4 sleep and 5 deep sleep. req_ready is 1 only in normal mode. A request with req_valid and req_ready both high takes effect on the next clock edge. A request made while req_ready is 0 is dropped.
- R3: Idle and deep idle clear only cpu_clk_en and leave the PLL and supply enables high. In either mode, irq high at a clock edge returns the controller to normal at that edge.
- R4: A deep idle request is taken only while clk13_sel is 1. When clk13_sel is 0 the controller stays in normal mode and req_err is set.
- R5: A request with code 6 or 7 leaves the mode unchanged and sets req_err. A request with code 0 changes nothing and raises no error.
- R6: Once set, req_err stays 1 until reset.
- R7: Standby clears cpu_clk_en and both pll_en bits and keeps both supply enables high. irq has no effect in standby. An enabled wake event returns the controller to normal without a warm reset.
- R8: Sleep clears cpu_clk_en, both pll_en bits and lv_supply_en, and keeps hv_supply_en high.
- R9: Deep sleep clears every enable output, including hv_supply_en.
- R10: A wake event in sleep or deep sleep returns the controller to normal and drives warm_rst_req high for exactly one cycle.
- R11: A wake event is a rising edge on a wake_in bit whose wake_en bit is 1. It takes effect on the third clock edge after the input changes. The following have no effect: disabled bits, falling edges, and levels that are held high.
- R12: A wake event also ends idle and deep idle. In normal mode a wake event has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A mode request is offered |
| req_ready | output | 1 | A request can be taken (normal mode) |
| req_mode | input | 3 | Requested mode code |
| irq | input | 1 | Interrupt line, active high |
| wake_in | input | NWAKE | Asynchronous wake sources |
| wake_en | input | NWAKE | Per-bit wake enables |
| clk13_sel | input | 1 | Core clock is on the 13 MHz source |
| cpu_clk_en | output | 1 | CPU clock enable |
| pll_en | output | 2 | Enables for the core PLL [0] and the peripheral PLL [1] |
| lv_supply_en | output | 1 | Low-voltage supply enable |
| hv_supply_en | output | 1 | High-voltage supply enable |
| warm_rst_req | output | 1 | Reboot request after sleep or deep sleep |
| mode_code | output | 3 | Current mode |
| req_err | output | 1 | Sticky illegal-request flag |

## Verification
A handshake or an irq level shows on mode_code and on the enable outputs one clock edge after it is driven. A wake input shows three edges after it changes: two synchroniser flops and then the mode register. warm_rst_req stays high only for the cycle that follows that third edge. The driver changes its inputs on the falling edge and waits exactly that many edges before it queues the expected output vector. The monitor compares the vector one time unit after the next falling edge. For the wake path, an extra vector is queued after two edges to show that the mode has not yet moved.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [2:0] {
    M_NORMAL = 3'd0,
    M_IDLE   = 3'd1,
    M_DIDLE  = 3'd2,
    M_STBY   = 3'd3,
    M_SLEEP  = 3'd4,
    M_DSLEEP = 3'd5
  } mode_t;

  localparam int PLL_N = 2;

  function automatic logic is_deep_retain(mode_t m);
    return (m == M_SLEEP) || (m == M_DSLEEP);
  endfunction
endpackage

// File: rtl/lpm_wake_sync.sv
module lpm_wake_sync #(
  parameter int NWAKE  = 37,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NWAKE-1:0] wake_in,
  input  logic [NWAKE-1:0] wake_en,
  output logic             wake_evt
);
  logic [NWAKE-1:0] sync_q [STAGES];
  logic [NWAKE-1:0] last_q;
  logic [NWAKE-1:0] rise;

  // Synchroniser chain
  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[s] <= '0;
        else if (s == 0) sync_q[s] <= wake_in;
        else sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= '0;
    else        last_q <= sync_q[STAGES-1];
  end

  assign rise     = sync_q[STAGES-1] & ~last_q;
  assign wake_evt = |(rise & wake_en);

  // An event needs a freshly risen, synchronised bit
  assert_evt_from_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |-> (sync_q[STAGES-1] != last_q));
endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [2:0] req_mode,
  input  logic       irq,
  input  logic       wake_evt,
  input  logic       clk13_sel,
  output mode_t      mode,
  output logic       warm_rst,
  output logic       err
);
  mode_t mode_d;
  logic  warm_d, err_d;

  always_comb begin
    mode_d = mode;
    warm_d = 1'b0;
    err_d  = err;
    unique case (mode)
      M_NORMAL: if (req_valid) begin
        case (req_mode)
          3'd0: mode_d = M_NORMAL;
          3'd1, 3'd3, 3'd4, 3'd5: mode_d = mode_t'(req_mode);
          3'd2: if (clk13_sel) mode_d = M_DIDLE;
                else           err_d  = 1'b1;
          default: err_d = 1'b1;
        endcase
      end
      M_IDLE, M_DIDLE: if (irq || wake_evt) mode_d = M_NORMAL;
      M_STBY:          if (wake_evt) mode_d = M_NORMAL;
      M_SLEEP, M_DSLEEP: if (wake_evt) begin
        mode_d = M_NORMAL;
        warm_d = 1'b1;
      end
      default: mode_d = M_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= M_NORMAL;
      warm_rst <= 1'b0;
      err      <= 1'b0;
    end else begin
      mode     <= mode_d;
      warm_rst <= warm_d;
      err      <= err_d;
    end
  end

  assert_didle_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_NORMAL && req_valid && req_mode == 3'd2 && !clk13_sel)
      |=> (mode == M_NORMAL && err));
  assert_idle_irq_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == M_IDLE || mode == M_DIDLE) && irq) |=> (mode == M_NORMAL));
  assert_stby_irq_deaf_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_STBY && !wake_evt) |=> (mode == M_STBY));
  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  assert_warm_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    warm_rst |=> !warm_rst);
  assert_warm_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(warm_rst) |-> (mode == M_NORMAL && is_deep_retain($past(mode))));
endmodule

// File: rtl/lpm_out_decode.sv
module lpm_out_decode
  import lpm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  mode_t             mode,
  output logic              cpu_clk_en,
  output logic [PLL_N-1:0]  pll_en,
  output logic              lv_en,
  output logic              hv_en
);
  always_comb begin
    cpu_clk_en = 1'b0;
    pll_en     = '0;
    lv_en      = 1'b0;
    hv_en      = 1'b0;
    case (mode)
      M_NORMAL: begin cpu_clk_en = 1'b1; pll_en = '1; lv_en = 1'b1; hv_en = 1'b1; end
      M_IDLE, M_DIDLE: begin pll_en = '1; lv_en = 1'b1; hv_en = 1'b1; end
      M_STBY:  begin lv_en = 1'b1; hv_en = 1'b1; end
      M_SLEEP: hv_en = 1'b1;
      default: ;
    endcase
  end

  // Supplies drop in order: high-voltage never goes before low-voltage
  assert_supply_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !hv_en |-> (!lv_en && pll_en == '0 && !cpu_clk_en));
  assert_lv_implies_pll_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !lv_en |-> (pll_en == '0));
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int NWAKE       = 37,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_mode,
  input  logic             irq,
  input  logic [NWAKE-1:0] wake_in,
  input  logic [NWAKE-1:0] wake_en,
  input  logic             clk13_sel,
  output logic             cpu_clk_en,
  output logic [1:0]       pll_en,
  output logic             lv_supply_en,
  output logic             hv_supply_en,
  output logic             warm_rst_req,
  output logic [2:0]       mode_code,
  output logic             req_err
);
  mode_t mode;
  logic  wake_evt;

  lpm_wake_sync #(.NWAKE(NWAKE), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .wake_in(wake_in), .wake_en(wake_en),
    .wake_evt(wake_evt)
  );

  lpm_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid & req_ready),
    .req_mode(req_mode), .irq(irq), .wake_evt(wake_evt),
    .clk13_sel(clk13_sel), .mode(mode), .warm_rst(warm_rst_req),
    .err(req_err)
  );

  lpm_out_decode u_dec (
    .clk(clk), .rst_n(rst_n), .mode(mode), .cpu_clk_en(cpu_clk_en),
    .pll_en(pll_en), .lv_en(lv_supply_en), .hv_en(hv_supply_en)
  );

  assign req_ready = (mode == M_NORMAL);
  assign mode_code = mode;

  assert_ready_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !wake_evt && !irq) |=> $stable(mode_code));
  assert_normal_deaf_wake_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_NORMAL && !req_valid) |=> (mode_code == 3'd0));
endmodule

// File: tb/sim_lpm_ctrl.sv
module sim_lpm_ctrl;
  localparam int NW = 37;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [2:0] req_mode = '0;
  logic irq = 1'b0;
  logic [NW-1:0] wake_in = '0;
  logic [NW-1:0] wake_en;
  logic clk13_sel = 1'b0;
  logic cpu_clk_en, lv_supply_en, hv_supply_en, warm_rst_req, req_err;
  logic [1:0] pll_en;
  logic [2:0] mode_code;

  always #5 clk = ~clk;

  lpm_ctrl #(.NWAKE(NW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .irq(irq), .wake_in(wake_in), .wake_en(wake_en),
    .clk13_sel(clk13_sel), .cpu_clk_en(cpu_clk_en), .pll_en(pll_en),
    .lv_supply_en(lv_supply_en), .hv_supply_en(hv_supply_en),
    .warm_rst_req(warm_rst_req), .mode_code(mode_code), .req_err(req_err)
  );

  typedef struct { string tag; logic [10:0] val; } item_t;
  item_t sbq[$];
  int n_vec = 0, n_bad = 0;
  logic exp_err = 1'b0;
  bit   done = 0;

  function automatic logic [10:0] expv(int m, logic warm, logic err);
    logic [4:0] en;
    case (m)
      0: en = 5'b1_11_1_1;
      1, 2: en = 5'b0_11_1_1;
      3: en = 5'b0_00_1_1;
      4: en = 5'b0_00_0_1;
      default: en = 5'b0_00_0_0;
    endcase
    return {3'(m), en, warm, err, (m == 0)};
  endfunction

  task automatic push(string tag, int m, logic warm = 1'b0);
    item_t it;
    it.tag = tag;
    it.val = expv(m, warm, exp_err);
    sbq.push_back(it);
  endtask

  // Monitor: compares queued expectations just after the falling edge
  initial forever begin
    @(negedge clk); #1;
    while (sbq.size() > 0) begin
      item_t it;
      logic [10:0] act;
      it  = sbq.pop_front();
      act = {mode_code, cpu_clk_en, pll_en, lv_supply_en, hv_supply_en,
             warm_rst_req, req_err, req_ready};
      n_vec++;
      if (act !== it.val) begin
        n_bad++;
        $display("FAIL %s: got %b exp %b", it.tag, act, it.val);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1; exp_err = 1'b0;
  endtask

  task automatic req(int m);
    req_valid = 1'b1; req_mode = 3'(m);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic pulse_irq();
    irq = 1'b1; @(negedge clk); irq = 1'b0;
  endtask

  task automatic wake_rise(int b, int n);
    wake_in[b] = 1'b1; repeat (n) @(negedge clk);
  endtask

  task automatic wake_fall(int b);
    wake_in[b] = 1'b0; repeat (4) @(negedge clk);
  endtask

  initial begin
    wake_en = '1; wake_en[5] = 1'b0;
    do_reset();
    push("R1 reset state", 0);
    @(negedge clk);

    req(1); push("R2 R3 idle entry", 1);
    req(4); push("R2 request dropped while busy", 1);
    pulse_irq(); push("R3 irq ends idle", 0);

    req(7); exp_err = 1'b1; push("R5 code 7 ignored", 0);
    repeat (3) @(negedge clk); push("R6 error sticky", 0);
    req(0); push("R5 code 0 no effect", 0);

    do_reset(); push("R1 reset clears error", 0);
    clk13_sel = 1'b0;
    req(2); exp_err = 1'b1; push("R4 deep idle refused", 0);
    clk13_sel = 1'b1;
    req(2); push("R4 R3 deep idle entry", 2);
    pulse_irq(); push("R3 irq ends deep idle", 0);

    req(3); push("R7 standby outputs", 3);
    pulse_irq(); push("R7 irq ignored in standby", 3);
    wake_rise(5, 4); push("R11 disabled bit ignored", 3);
    wake_fall(5); push("R11 falling edge ignored", 3);
    wake_rise(36, 2); push("R11 not yet at edge two", 3);
    @(negedge clk); push("R7 R11 wake at edge three", 0);
    wake_fall(36);

    req(4); push("R8 sleep outputs", 4);
    wake_rise(0, 3); push("R10 sleep exit with reboot", 0, 1'b1);
    @(negedge clk); push("R10 reboot pulse one cycle", 0);
    wake_fall(0);

    req(5); push("R9 deep sleep outputs", 5);
    wake_rise(20, 3); push("R10 deep sleep exit with reboot", 0, 1'b1);
    @(negedge clk); push("R10 reboot pulse ends", 0);
    wake_fall(20);

    wake_rise(3, 4); push("R12 wake ignored in normal", 0);
    req(3); repeat (4) @(negedge clk); push("R11 held level no retrigger", 3);
    wake_fall(3);
    wake_rise(3, 3); push("R11 new edge wakes", 0);
    wake_fall(3);

    req(1);
    wake_rise(10, 3); push("R12 wake ends idle", 0);
    wake_fall(10);

    repeat (2) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule